// File: doc/BRIEF.md
# Radio FIFO Fill and Transmit-Start Controller

This block holds the control and status logic that sits beside the byte FIFO in the digital back end of a packet radio. It decides when received bytes may enter the FIFO. In automatic fill, a detected sync word starts the fill. In manual fill, software switches filling on and off through the register. On the transmit side, it decides from the FIFO occupancy and the selected data mode when transmission may begin. It also drives the IRQ0 line that goes with that decision.

One 8-bit register holds the configuration, the live status and two sticky event flags. The first flag records that the received signal level has risen above a programmable threshold. The second records that the synthesizer PLL has locked. Software clears either flag by writing a 1 to it. A transmit-done bit reports that the final bit has left the transmit shift register. The FIFO storage, the modem and the PLL are outside this block. The block only sees their status pins.

The register port is a plain single-cycle write strobe with data, plus a combinational read-back. None of the interfaces carry a data stream, so none of them use a valid/ready handshake. A write always completes in the cycle it is presented.

Top module: `radio_fifo_ctrl`

## Requirements
- R1: After reset the register reads 0x01. Fill enable, transmit start and IRQ0 are all low.
- R2: When bit 7 = 0 (automatic fill) and the mode is not 00, a one-cycle sync pulse makes fill enable and register bit 6 read 1 from the next cycle.
- R3: In automatic fill, FIFO full during filling clears fill enable and bit 6 on the next cycle. Filling then stays off until the next sync pulse starts it again.
- R4: A register write whose data has bit 7 = 1 sets filling to that data's bit 6. Under manual fill, sync pulses and FIFO full leave filling unchanged.
- R5: A write whose data has bit 7 = 0 ignores its bit 6. Filling keeps its state.
- R6: In mode 01 (buffered), transmit start is asserted when bit 4 = 1 and the FIFO is not empty, or when bit 4 = 0 and the FIFO is full. IRQ0 equals FIFO empty.
- R7: In modes 10 and 11 (packet), bit 4 = 1 starts on not-empty, with IRQ0 equal to FIFO empty. Bit 4 = 0 starts when the count is at or above the 6-bit threshold, with IRQ0 equal to that comparison.
- R8: In mode 00 (continuous), transmit start and IRQ0 are low and filling is held off. Sync pulses have no effect.
- R9: Bit 5 (transmit done) is 0 while the shift-register-empty input is low. It becomes 1 one cycle after the shift register and the FIFO are both empty, following a transmission. It is forced to 0 in mode 00.
- R10: Bit 2 sets on a rising edge of (RSSI level > RSSI threshold, strictly greater) while bit 3 = 1. While bit 3 = 0, the flag cannot set and otherwise holds its value.
- R11: Bit 1 sets on a rising edge of PLL lock while bit 0 = 1. With bit 0 = 0, a lock edge leaves it at 0.
- R12: Writing 1 to bit 2 or bit 1 clears that flag. Writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag at 1.
- R13: Bits 7, 4, 3 and 0 read back what was written. Bit 5 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back, combinational |
| mode | input | 2 | Data mode: 00 continuous, 01 buffered, 1x packet |
| fifo_count | input | CNT_W | Bytes currently in the FIFO |
| fifo_empty | input | 1 | FIFO holds no bytes |
| fifo_full | input | 1 | FIFO holds its maximum |
| fill_thresh | input | THR_W | Packet-mode transmit threshold |
| sync_det | input | 1 | Sync word detected, one-cycle pulse |
| shreg_empty | input | 1 | Transmit shift register has emptied |
| rssi_level | input | LVL_W | Measured signal level |
| rssi_thresh | input | LVL_W | Signal level threshold |
| pll_locked | input | 1 | PLL lock indication |
| fill_en | output | 1 | FIFO may accept received bytes |
| tx_start | output | 1 | Transmission may begin |
| irq0 | output | 1 | Interrupt line for the transmit-start condition |

## Verification
The bench builds the block with its defaults: a 7-bit count, a 6-bit threshold and 8-bit levels. With these widths a count of 64, a full 64-byte FIFO, lies inside the comparison range. So does the top threshold value of 63, and the bench tests both just below and exactly at the threshold. The level checks use a level equal to the threshold and one step above it, which probes the strict comparison. Both packet mode codes are exercised, so the don't-care low mode bit is covered.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    DM_CONT  = 2'b00,
    DM_BUF   = 2'b01,
    DM_PKT_A = 2'b10,
    DM_PKT_B = 2'b11
  } dmode_e;

  // register bit positions (software decodes these)
  localparam int unsigned B_METHOD    = 7;
  localparam int unsigned B_FILL      = 6;
  localparam int unsigned B_TXDONE    = 5;
  localparam int unsigned B_TXSEL     = 4;
  localparam int unsigned B_RSSI_EN   = 3;
  localparam int unsigned B_RSSI_FLAG = 2;
  localparam int unsigned B_PLL_FLAG  = 1;
  localparam int unsigned B_PLL_EN    = 0;

  localparam logic [7:0] CFG_RESET   = 8'h01;
  localparam logic [7:0] CFG_RW_MASK = 8'h99;

  localparam int unsigned N_FLAGS = 2;
  localparam int unsigned F_RSSI  = 0;
  localparam int unsigned F_PLL   = 1;

endpackage

// File: rtl/rfc_fill_ctrl.sv
module rfc_fill_ctrl
  import rfc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  dmode_e mode,
  input  logic   manual,
  input  logic   sw_wr,
  input  logic   sw_val,
  input  logic   sync_det,
  input  logic   fifo_full,
  output logic   filling
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filling <= 1'b0;
    end else if (mode == DM_CONT) begin
      filling <= 1'b0;
    end else if (sw_wr) begin
      filling <= sw_val;
    end else if (!manual) begin
      if (filling && fifo_full) begin
        filling <= 1'b0;
      end else if (sync_det) begin
        filling <= 1'b1;
      end
    end
  end

  assert_cont_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DM_CONT) |=> !filling);

  assert_sync_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != DM_CONT && !sw_wr && !manual && !filling && sync_det) |=> filling);

  assert_auto_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != DM_CONT && !sw_wr && !manual && filling && fifo_full) |=> !filling);

  assert_manual_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != DM_CONT && !sw_wr && manual) |=> $stable(filling));

endmodule

// File: rtl/rfc_tx_ctrl.sv
module rfc_tx_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dmode_e           mode,
  input  logic             start_sel,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic [THR_W-1:0] thresh,
  input  logic             shreg_empty,
  output logic             tx_start,
  output logic             irq0,
  output logic             tx_done
);

  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] thr_x;
  logic             thresh_met;
  logic             busy_q;

  assign cnt_x      = CMP_W'(fifo_count);
  assign thr_x      = CMP_W'(thresh);
  assign thresh_met = (cnt_x >= thr_x);

  always_comb begin
    unique case (mode)
      DM_CONT: begin
        tx_start = 1'b0;
        irq0     = 1'b0;
      end
      DM_BUF: begin
        tx_start = start_sel ? !fifo_empty : fifo_full;
        irq0     = fifo_empty;
      end
      default: begin
        tx_start = start_sel ? !fifo_empty : thresh_met;
        irq0     = start_sel ? fifo_empty : thresh_met;
      end
    endcase
  end

  // done only after a transmission drained both FIFO and shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tx_done <= 1'b0;
    end else if (mode == DM_CONT) begin
      busy_q  <= 1'b0;
      tx_done <= 1'b0;
    end else if (!shreg_empty) begin
      busy_q  <= 1'b1;
      tx_done <= 1'b0;
    end else if (busy_q && fifo_empty) begin
      busy_q  <= 1'b0;
      tx_done <= 1'b1;
    end
  end

  assert_cont_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DM_CONT) |-> (!tx_start && !irq0));

  assert_buf_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DM_BUF) |-> (irq0 == fifo_empty));

  assert_pkt_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == DM_PKT_A || mode == DM_PKT_B) && !start_sel && (cnt_x < thr_x))
      |-> !tx_start);

  assert_busy_nodone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shreg_empty) |=> !tx_done);

endmodule

// File: rtl/rfc_sticky_flag.sv
module rfc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic arm,
  input  logic clr,
  output logic flag
);

  logic src_q;
  logic hit;

  // edge tracking runs even while disarmed, so arming mid-level does not set
  assign hit = arm && src && !src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      src_q <= src;
      flag  <= hit | (flag & ~clr);
    end
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);

  assert_masked_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !clr) |=> $stable(flag));

endmodule

// File: rtl/radio_fifo_ctrl.sv
module radio_fifo_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned THR_W = 6,
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic [THR_W-1:0] fill_thresh,
  input  logic             sync_det,
  input  logic             shreg_empty,
  input  logic [LVL_W-1:0] rssi_level,
  input  logic [LVL_W-1:0] rssi_thresh,
  input  logic             pll_locked,
  output logic             fill_en,
  output logic             tx_start,
  output logic             irq0
);

  dmode_e             dmode;
  logic [7:0]         cfg_q;
  logic               tx_done;
  logic [N_FLAGS-1:0] fl_src;
  logic [N_FLAGS-1:0] fl_arm;
  logic [N_FLAGS-1:0] fl_clr;
  logic [N_FLAGS-1:0] fl_q;
  logic [7:0]         status;

  assign dmode = dmode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (reg_wr_en) begin
      cfg_q <= reg_wdata;
    end
  end

  rfc_fill_ctrl u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (dmode),
    .manual    (cfg_q[B_METHOD]),
    .sw_wr     (reg_wr_en && reg_wdata[B_METHOD]),
    .sw_val    (reg_wdata[B_FILL]),
    .sync_det  (sync_det),
    .fifo_full (fifo_full),
    .filling   (fill_en)
  );

  rfc_tx_ctrl #(
    .CNT_W (CNT_W),
    .THR_W (THR_W)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (dmode),
    .start_sel   (cfg_q[B_TXSEL]),
    .fifo_count  (fifo_count),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .thresh      (fill_thresh),
    .shreg_empty (shreg_empty),
    .tx_start    (tx_start),
    .irq0        (irq0),
    .tx_done     (tx_done)
  );

  assign fl_src[F_RSSI] = (rssi_level > rssi_thresh);
  assign fl_arm[F_RSSI] = cfg_q[B_RSSI_EN];
  assign fl_clr[F_RSSI] = reg_wr_en && reg_wdata[B_RSSI_FLAG];
  assign fl_src[F_PLL]  = pll_locked;
  assign fl_arm[F_PLL]  = cfg_q[B_PLL_EN];
  assign fl_clr[F_PLL]  = reg_wr_en && reg_wdata[B_PLL_FLAG];

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    rfc_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (fl_src[g]),
      .arm   (fl_arm[g]),
      .clr   (fl_clr[g]),
      .flag  (fl_q[g])
    );
  end

  always_comb begin
    status              = '0;
    status[B_FILL]      = fill_en;
    status[B_TXDONE]    = tx_done;
    status[B_RSSI_FLAG] = fl_q[F_RSSI];
    status[B_PLL_FLAG]  = fl_q[F_PLL];
  end

  assign reg_rdata = (cfg_q & CFG_RW_MASK) | status;

  assert_cfg_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> ((reg_rdata & CFG_RW_MASK) == ($past(reg_wdata) & CFG_RW_MASK)));

endmodule

// File: tb/radio_fifo_ctrl_test.sv
module radio_fifo_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] mode = 2'b00;
  logic [6:0] fifo_count = '0;
  logic       fifo_empty = 1'b1;
  logic       fifo_full = 1'b0;
  logic [5:0] fill_thresh = '0;
  logic       sync_det = 1'b0;
  logic       shreg_empty = 1'b1;
  logic [7:0] rssi_level = '0;
  logic [7:0] rssi_thresh = 8'd100;
  logic       pll_locked = 1'b0;
  logic       fill_en, tx_start, irq0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_fifo_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mode(mode), .fifo_count(fifo_count),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fill_thresh(fill_thresh),
    .sync_det(sync_det), .shreg_empty(shreg_empty), .rssi_level(rssi_level),
    .rssi_thresh(rssi_thresh), .pll_locked(pll_locked), .fill_en(fill_en),
    .tx_start(tx_start), .irq0(irq0)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_det = 1'b1;
    step();
    sync_det = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 8'h01);
    chk("R1 fill_en", fill_en, 0);
    chk("R1 tx_start", tx_start, 0);
    chk("R1 irq0", irq0, 0);
  endtask

  task automatic t_readback();
    mode = 2'b00;
    wr(8'hFF);
    chk("R13 rw bits only", reg_rdata, 8'h99);
    wr(8'h01);
    chk("R13 restore", reg_rdata, 8'h01);
  endtask

  task automatic t_auto_fill();
    mode = 2'b01;
    pulse_sync();
    chk("R2 fill_en after sync", fill_en, 1);
    chk("R2 status bit", reg_rdata, 8'h41);
    fifo_full = 1'b1;
    step();
    chk("R3 stop on full", fill_en, 0);
    chk("R3 status cleared", reg_rdata, 8'h01);
    fifo_full = 1'b0;
    step();
    chk("R3 stays off until sync", fill_en, 0);
    pulse_sync();
    chk("R3 re-armed", fill_en, 1);
    fifo_full = 1'b1;
    step();
    fifo_full = 1'b0;
    chk("R3 second stop", fill_en, 0);
  endtask

  task automatic t_auto_ignore();
    wr(8'h41);
    chk("R5 bit6 ignored in auto", fill_en, 0);
    chk("R5 rdata", reg_rdata, 8'h01);
    pulse_sync();
    chk("R5 auto still works", fill_en, 1);
    wr(8'h01);
    chk("R5 write keeps filling", fill_en, 1);
    fifo_full = 1'b1;
    step();
    fifo_full = 1'b0;
    chk("R5 stop", fill_en, 0);
  endtask

  task automatic t_manual();
    wr(8'hC1);
    chk("R4 manual start", fill_en, 1);
    chk("R4 rdata", reg_rdata, 8'hC1);
    fifo_full = 1'b1;
    step();
    fifo_full = 1'b0;
    chk("R4 full ignored in manual", fill_en, 1);
    wr(8'h81);
    chk("R4 manual stop", fill_en, 0);
    pulse_sync();
    chk("R4 sync ignored in manual", fill_en, 0);
    wr(8'h01);
  endtask

  task automatic t_buffered();
    mode = 2'b01;
    fifo_empty = 1'b1; fifo_full = 1'b0; #1;
    chk("R6 sel0 empty tx", tx_start, 0);
    chk("R6 sel0 empty irq", irq0, 1);
    fifo_empty = 1'b0; #1;
    chk("R6 sel0 partial tx", tx_start, 0);
    chk("R6 sel0 partial irq", irq0, 0);
    fifo_full = 1'b1; #1;
    chk("R6 sel0 full tx", tx_start, 1);
    fifo_full = 1'b0;
    wr(8'h11);
    chk("R6 sel1 not-empty tx", tx_start, 1);
    chk("R6 sel1 irq", irq0, 0);
    fifo_empty = 1'b1; #1;
    chk("R6 sel1 empty tx", tx_start, 0);
    chk("R6 sel1 empty irq", irq0, 1);
  endtask

  task automatic t_packet();
    mode = 2'b10;
    wr(8'h01);
    fill_thresh = 6'd20; fifo_empty = 1'b0; fifo_count = 7'd19; #1;
    chk("R7 below thresh tx", tx_start, 0);
    chk("R7 below thresh irq", irq0, 0);
    fifo_count = 7'd20; #1;
    chk("R7 at thresh tx", tx_start, 1);
    chk("R7 at thresh irq", irq0, 1);
    mode = 2'b11; fifo_count = 7'd64; #1;
    chk("R7 mode11 count64 tx", tx_start, 1);
    fill_thresh = 6'd63; fifo_count = 7'd62; #1;
    chk("R7 thresh63 below", tx_start, 0);
    wr(8'h11);
    fifo_count = 7'd5; #1;
    chk("R7 sel1 tx", tx_start, 1);
    chk("R7 sel1 irq", irq0, 0);
    fifo_empty = 1'b1; fifo_count = 7'd0; #1;
    chk("R7 sel1 empty tx", tx_start, 0);
    chk("R7 sel1 empty irq", irq0, 1);
  endtask

  task automatic t_cont();
    mode = 2'b00;
    wr(8'h01);
    fifo_full = 1'b1; fifo_empty = 1'b0; fifo_count = 7'd64; fill_thresh = 6'd0; #1;
    chk("R8 tx low", tx_start, 0);
    chk("R8 irq low", irq0, 0);
    pulse_sync();
    chk("R8 no fill", fill_en, 0);
    chk("R8 rdata", reg_rdata, 8'h01);
    fifo_full = 1'b0; fifo_empty = 1'b1; fifo_count = 7'd0;
  endtask

  task automatic t_txdone();
    mode = 2'b01;
    shreg_empty = 1'b1; fifo_empty = 1'b1;
    step();
    chk("R9 idle no done", reg_rdata[5], 0);
    shreg_empty = 1'b0;
    step();
    chk("R9 busy", reg_rdata[5], 0);
    shreg_empty = 1'b1; fifo_empty = 1'b0;
    step();
    chk("R9 fifo not drained", reg_rdata[5], 0);
    fifo_empty = 1'b1;
    step();
    chk("R9 done set", reg_rdata[5], 1);
    step();
    chk("R9 done holds", reg_rdata[5], 1);
    shreg_empty = 1'b0;
    step();
    chk("R9 new tx clears", reg_rdata[5], 0);
    shreg_empty = 1'b1;
    step();
    chk("R9 done again", reg_rdata[5], 1);
    mode = 2'b00;
    step();
    chk("R9 cont forces 0", reg_rdata[5], 0);
  endtask

  task automatic t_rssi();
    wr(8'h09);
    rssi_level = 8'd100;
    step();
    chk("R10 equal not above", reg_rdata[2], 0);
    rssi_level = 8'd101;
    step();
    chk("R10 above sets", reg_rdata[2], 1);
    wr(8'h0D);
    chk("R12 w1c clears", reg_rdata[2], 0);
    step();
    chk("R10 level alone no reset", reg_rdata[2], 0);
    rssi_level = 8'd50; step();
    rssi_level = 8'd150; step();
    chk("R10 new edge", reg_rdata[2], 1);
    wr(8'h01);
    chk("R10 disable holds", reg_rdata[2], 1);
    rssi_level = 8'd50; step();
    rssi_level = 8'd150; step();
    chk("R10 masked holds 1", reg_rdata[2], 1);
    wr(8'h05);
    chk("R12 clear while masked", reg_rdata[2], 0);
    rssi_level = 8'd50; step();
    rssi_level = 8'd150; step();
    chk("R10 masked no set", reg_rdata[2], 0);
    wr(8'h09);
    chk("R10 arm mid-level no set", reg_rdata[2], 0);
    rssi_level = 8'd50; step();
    rssi_level = 8'd150;
    wr(8'h0D);
    chk("R12 set wins over clear", reg_rdata[2], 1);
    wr(8'h09);
    chk("R12 write 0 no effect", reg_rdata[2], 1);
    wr(8'h0D);
    chk("R12 clear", reg_rdata[2], 0);
    rssi_level = 8'd0;
  endtask

  task automatic t_pll();
    wr(8'h01);
    pll_locked = 1'b1;
    step();
    chk("R11 lock sets", reg_rdata[1], 1);
    wr(8'h03);
    chk("R12 pll clear", reg_rdata[1], 0);
    pll_locked = 1'b0; step();
    wr(8'h00);
    pll_locked = 1'b1; step();
    chk("R11 disabled no set", reg_rdata[1], 0);
    pll_locked = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_readback();
    t_auto_fill();
    t_auto_ignore();
    t_manual();
    t_buffered();
    t_packet();
    t_cont();
    t_txdone();
    t_rssi();
    t_pll();
    finish_run();
  end

endmodule